// File: doc/BRIEF.md
# DMA Channel Eligibility Scheduler

This block arbitrates a 32-channel DMA micro-engine that runs one channel at a time and is never preempted. Each channel has four flags: host enable (HE), event pending (EP), host override (HO) and event override (EO). A channel can run when `(HE | HO) & (EP | EO)` holds and its programmed priority is not zero. The host sets and clears these flags through a small write port. Peripheral request lines raise EP. The core reports yields on a dedicated port, giving the kind of yield and the number of the running channel.

A new channel is chosen only when the core is asleep, when it yields, or when the host forces a reschedule. The winner is the eligible channel with the highest priority. On a tie, the lowest index wins. The block then issues a one-cycle load strobe with the channel number and marks the core busy. Saving and restoring context is left to the engine.

Top module: `dma_ch_sched`

## Requirements
- R1: After reset `busy_o`, `load_o`, `he_o`, `ep_o` and `elig_o` are all zero. HO, EO and every channel priority also start at zero.
- R2: `elig_o[i]` equals `(HE[i] | HO[i]) & (EP[i] | EO[i])` for every channel.
- R3: Host writes act by `host_addr_i` as follows:
  - 0: HE |= data.
  - 1: HE &= ~data.
  - 2: HO = data.
  - 3: EO = data.
  - 4: the priority of the channel in `data[4:0]` becomes `data[10:8]`.
- R4: A high bit of `evt_req_i` sets that channel's EP. When it falls in the same cycle as a clear of the same channel's EP by a yield, the set wins.
- R5: While the core is idle, the block picks the eligible channel with the highest non-zero priority, with ties going to the lowest index. It then pulses `load_o` for one cycle with that channel on `load_ch_o`, and raises `busy_o`.
- R6: A channel with priority 0 is never loaded. If no channel can be picked, `busy_o` stays low and no load occurs.
- R7: While `busy_o` is high, no load occurs unless the core reports a yield that releases it.
- R8: Yield kind 0 releases the core only if some other channel that can be picked has strictly higher priority than the yielding channel. The block then loads the best such channel in the next cycle.
- R9: Yield kind 1 releases the core if some other channel that can be picked has higher or equal priority. The block then loads the best such channel in the next cycle.
- R10: Yield kinds 0 and 1 leave HE and EP of the yielding channel unchanged.
- R11: Yield kinds 2 and 3 always release the core. Kind 2 clears the channel's HE, and kind 3 clears both its HE and its EP. `busy_o` drops, and a fresh pick from all channels follows.
- R12: A write to address 5 acts on two control bits:
  - Bit 0 forces a reschedule: `busy_o` drops and a fresh pick follows.
  - Bit 1 clears all HE and EP flags and drops `busy_o`, with no load in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host register write strobe |
| host_addr_i | input | 3 | Host register address |
| host_wdata_i | input | 32 | Host write data |
| evt_req_i | input | 32 | Per-channel peripheral request pulses |
| yld_valid_i | input | 1 | Core yield report valid |
| yld_kind_i | input | 2 | Yield kind: 0 strict, 1 higher-or-equal, 2 done (HE), 3 done (HE and EP) |
| yld_ch_i | input | 5 | Channel issuing the yield |
| load_o | output | 1 | One-cycle load strobe |
| load_ch_o | output | 5 | Channel to load |
| busy_o | output | 1 | Core is running a channel |
| he_o | output | 32 | Host enable flags |
| ep_o | output | 32 | Event pending flags |
| elig_o | output | 32 | Eligibility vector |

## Verification
The bench builds the block with its default 32 channels and 3-bit priorities. This brings the whole priority range into reach, including the zero level that disables a channel and the top level 7, where the strict and higher-or-equal yields differ on a tie. With a wide channel set, the tests can place ties between far-apart indices such as 4 and 20. They can also exercise each path to eligibility separately: host enable with event override, and host override with event pending.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int ADDR_W   = 3;
  localparam int PRIO_LSB = 8;

  localparam logic [ADDR_W-1:0] A_SET_HE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CLR_HE = 3'd1;
  localparam logic [ADDR_W-1:0] A_HO     = 3'd2;
  localparam logic [ADDR_W-1:0] A_EO     = 3'd3;
  localparam logic [ADDR_W-1:0] A_PRIO   = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd5;

  localparam int CTL_RESCHED = 0;
  localparam int CTL_RESET   = 1;

  typedef enum logic [1:0] {
    YK_STRICT = 2'd0,
    YK_GE     = 2'd1,
    YK_DONE_H = 2'd2,
    YK_DONE_A = 2'd3
  } yld_kind_e;
endpackage

// File: rtl/dma_flag_bank.sv
module dma_flag_bank
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int PRIO_W  = 3,
  parameter int HDATA_W = 32,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           host_we_i,
  input  logic [ADDR_W-1:0]              host_addr_i,
  input  logic [HDATA_W-1:0]             host_wdata_i,
  input  logic [NUM_CH-1:0]              evt_req_i,
  input  logic [NUM_CH-1:0]              core_clr_he_i,
  input  logic [NUM_CH-1:0]              core_clr_ep_i,
  input  logic                           rst_cmd_i,
  output logic [NUM_CH-1:0]              he_o,
  output logic [NUM_CH-1:0]              ep_o,
  output logic [NUM_CH-1:0]              ho_o,
  output logic [NUM_CH-1:0]              eo_o,
  output logic [NUM_CH-1:0][PRIO_W-1:0]  prio_o
);
  logic [NUM_CH-1:0] wmask;
  logic [NUM_CH-1:0] host_set_he, host_clr_he;
  logic [NUM_CH-1:0] he_d, ep_d;
  logic [CH_W-1:0]   prio_ch;
  logic [PRIO_W-1:0] prio_val;

  assign wmask       = host_wdata_i[NUM_CH-1:0];
  assign host_set_he = (host_we_i && host_addr_i == A_SET_HE) ? wmask : '0;
  assign host_clr_he = (host_we_i && host_addr_i == A_CLR_HE) ? wmask : '0;
  assign prio_ch     = host_wdata_i[CH_W-1:0];
  assign prio_val    = host_wdata_i[PRIO_LSB +: PRIO_W];

  // set beats clear on both flags
  assign he_d = (he_o & ~host_clr_he & ~core_clr_he_i) | host_set_he;
  assign ep_d = (ep_o & ~core_clr_ep_i) | evt_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      he_o <= '0;
      ep_o <= '0;
    end else if (rst_cmd_i) begin
      he_o <= '0;
      ep_o <= '0;
    end else begin
      he_o <= he_d;
      ep_o <= ep_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ho_o   <= '0;
      eo_o   <= '0;
      prio_o <= '0;
    end else if (host_we_i) begin
      if (host_addr_i == A_HO) ho_o <= wmask;
      if (host_addr_i == A_EO) eo_o <= wmask;
      if (host_addr_i == A_PRIO) prio_o[prio_ch] <= prio_val;
    end
  end
endmodule

// File: rtl/dma_sched_pick.sv
module dma_sched_pick #(
  parameter int NUM_CH = 32,
  parameter int PRIO_W = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]             cand_i,
  input  logic [NUM_CH-1:0][PRIO_W-1:0] prio_i,
  output logic                          found_o,
  output logic [CH_W-1:0]               ch_o
);
  logic [PRIO_W-1:0] best;

  // scan high to low with >= so the lowest index wins a tie
  always_comb begin
    found_o = 1'b0;
    ch_o    = '0;
    best    = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand_i[i] && (!found_o || prio_i[i] >= best)) begin
        found_o = 1'b1;
        ch_o    = CH_W'(i);
        best    = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/dma_ch_sched.sv
module dma_ch_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_CH  = 32,
  parameter int PRIO_W  = 3,
  parameter int HDATA_W = 32,
  localparam int CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [HDATA_W-1:0] host_wdata_i,
  input  logic [NUM_CH-1:0]  evt_req_i,
  input  logic               yld_valid_i,
  input  logic [1:0]         yld_kind_i,
  input  logic [CH_W-1:0]    yld_ch_i,
  output logic               load_o,
  output logic [CH_W-1:0]    load_ch_o,
  output logic               busy_o,
  output logic [NUM_CH-1:0]  he_o,
  output logic [NUM_CH-1:0]  ep_o,
  output logic [NUM_CH-1:0]  elig_o
);
  logic [NUM_CH-1:0]             ho, eo, prio_nz, cand, cand_oth, run_oh;
  logic [NUM_CH-1:0][PRIO_W-1:0] prio;
  logic [NUM_CH-1:0]             clr_he, clr_ep;
  logic                          all_found, oth_found;
  logic [CH_W-1:0]               all_ch, oth_ch;
  logic [PRIO_W-1:0]             run_prio, oth_prio;
  logic                          ctrl_we, rst_cmd, resched;
  logic                          yld_act, done_act, cond_rel;
  yld_kind_e                     kind;

  assign ctrl_we = host_we_i && host_addr_i == A_CTRL;
  assign rst_cmd = ctrl_we && host_wdata_i[CTL_RESET];
  assign resched = ctrl_we && host_wdata_i[CTL_RESCHED];

  assign kind     = yld_kind_e'(yld_kind_i);
  assign yld_act  = yld_valid_i && busy_o;
  assign done_act = yld_act && (kind == YK_DONE_H || kind == YK_DONE_A);
  assign run_oh   = NUM_CH'(1) << yld_ch_i;
  assign clr_he   = done_act ? run_oh : '0;
  assign clr_ep   = (done_act && kind == YK_DONE_A) ? run_oh : '0;

  dma_flag_bank #(
    .NUM_CH (NUM_CH),
    .PRIO_W (PRIO_W),
    .HDATA_W(HDATA_W)
  ) u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .evt_req_i    (evt_req_i),
    .core_clr_he_i(clr_he),
    .core_clr_ep_i(clr_ep),
    .rst_cmd_i    (rst_cmd),
    .he_o         (he_o),
    .ep_o         (ep_o),
    .ho_o         (ho),
    .eo_o         (eo),
    .prio_o       (prio)
  );

  assign elig_o = (he_o | ho) & (ep_o | eo);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_nz
    assign prio_nz[g] = |prio[g];
  end

  assign cand     = elig_o & prio_nz;
  assign cand_oth = cand & ~run_oh;

  dma_sched_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick_all (
    .cand_i (cand),
    .prio_i (prio),
    .found_o(all_found),
    .ch_o   (all_ch)
  );

  dma_sched_pick #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_pick_oth (
    .cand_i (cand_oth),
    .prio_i (prio),
    .found_o(oth_found),
    .ch_o   (oth_ch)
  );

  assign run_prio = prio[yld_ch_i];
  assign oth_prio = prio[oth_ch];

  always_comb begin
    cond_rel = 1'b0;
    if (yld_act && oth_found) begin
      if (kind == YK_STRICT) cond_rel = oth_prio > run_prio;
      else if (kind == YK_GE) cond_rel = oth_prio >= run_prio;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b0;
      load_o    <= 1'b0;
      load_ch_o <= '0;
    end else if (rst_cmd || done_act || resched) begin
      busy_o <= 1'b0;
      load_o <= 1'b0;
    end else if (cond_rel) begin
      load_o    <= 1'b1;
      load_ch_o <= oth_ch;
    end else if (!busy_o && all_found) begin
      busy_o    <= 1'b1;
      load_o    <= 1'b1;
      load_ch_o <= all_ch;
    end else begin
      load_o <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_ch_sched_chk.sv
module dma_ch_sched_chk #(
  parameter int NUM_CH = 32,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rst_cmd_i,
  input logic              resched_i,
  input logic [NUM_CH-1:0] evt_req_i,
  input logic              yld_valid_i,
  input logic [1:0]        yld_kind_i,
  input logic              load_o,
  input logic [CH_W-1:0]   load_ch_o,
  input logic              busy_o,
  input logic [NUM_CH-1:0] ep_o,
  input logic [NUM_CH-1:0] elig_o
);
  logic [NUM_CH-1:0] elig_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_d <= '0;
    else         elig_d <= elig_o;
  end

  // R5: a loaded channel was eligible in the deciding cycle
  p_load_elig_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> elig_d[load_ch_o]);

  // R7: a load while busy only follows a conditional yield
  p_no_preempt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && $past(busy_o)) |-> ($past(yld_valid_i) && $past(yld_kind_i) < 2'd2));

  // R4: a request always lands in EP
  p_evt_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt_req_i) && !rst_cmd_i) |=> ((ep_o & $past(evt_req_i)) == $past(evt_req_i)));

  // R6: nothing eligible while asleep means no load
  p_sleep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && elig_o == '0) |=> !load_o);

  // R11: core released only by done, reschedule or reset command
  p_busy_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (($past(yld_valid_i) && $past(yld_kind_i) >= 2'd2)
                       || $past(rst_cmd_i) || $past(resched_i)));
endmodule

bind dma_ch_sched dma_ch_sched_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rst_cmd_i  (rst_cmd),
  .resched_i  (resched),
  .evt_req_i  (evt_req_i),
  .yld_valid_i(yld_valid_i),
  .yld_kind_i (yld_kind_i),
  .load_o     (load_o),
  .load_ch_o  (load_ch_o),
  .busy_o     (busy_o),
  .ep_o       (ep_o),
  .elig_o     (elig_o)
);

// File: tb/sim_dma_ch_sched.sv
module sim_dma_ch_sched;
  import dma_sched_pkg::*;

  localparam int NUM_CH = 32;
  localparam int CH_W   = 5;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              host_we = 1'b0;
  logic [2:0]        host_addr = '0;
  logic [31:0]       host_wdata = '0;
  logic [NUM_CH-1:0] evt_req = '0;
  logic              yld_valid = 1'b0;
  logic [1:0]        yld_kind = '0;
  logic [CH_W-1:0]   yld_ch = '0;
  logic              load_o, busy_o;
  logic [CH_W-1:0]   load_ch_o;
  logic [NUM_CH-1:0] he_o, ep_o, elig_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] ho_m = '0;
  logic [31:0] eo_m = '0;

  always #4 clk = ~clk;

  dma_ch_sched u0 (
    .clk_i(clk), .rst_ni(rst_ni), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .evt_req_i(evt_req), .yld_valid_i(yld_valid),
    .yld_kind_i(yld_kind), .yld_ch_i(yld_ch), .load_o(load_o), .load_ch_o(load_ch_o),
    .busy_o(busy_o), .he_o(he_o), .ep_o(ep_o), .elig_o(elig_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic set_prio(input int ch, input int p);
    wr(A_PRIO, 32'(ch) | (32'(p) << PRIO_LSB));
  endtask

  task automatic yld(input logic [1:0] k, input int ch, input logic [31:0] ev);
    yld_valid = 1'b1; yld_kind = k; yld_ch = CH_W'(ch); evt_req = ev;
    @(negedge clk);
    yld_valid = 1'b0; evt_req = '0;
  endtask

  task automatic pulse_evt(input logic [31:0] ev);
    evt_req = ev;
    @(negedge clk);
    evt_req = '0;
  endtask

  task automatic wait_load(input string tag, input int exp_ch);
    logic seen = 1'b0;
    logic [CH_W-1:0] ch = '0;
    for (int i = 0; i < 4; i++) begin
      if (load_o) begin seen = 1'b1; ch = load_ch_o; break; end
      @(negedge clk);
    end
    chk({tag, " load seen"}, 32'(seen), 32'd1);
    chk({tag, " load ch"}, 32'(ch), 32'(exp_ch));
    chk({tag, " busy"}, 32'(busy_o), 32'd1);
  endtask

  task automatic no_load(input string tag, input int n);
    logic bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (load_o) bad = 1'b1;
    end
    chk({tag, " no load"}, 32'(bad), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 load", 32'(load_o), 0);
    chk("R1 he", he_o, 0);
    chk("R1 ep", ep_o, 0);
    chk("R1 elig", elig_o, 0);
  endtask

  task automatic t_elig;
    set_prio(3, 2);
    wr(A_SET_HE, 32'h8);
    chk("R2 he only", elig_o, 0);
    chk("R3 set he", he_o, 32'h8);
    no_load("R2 he only", 3);
    eo_m = 32'h8; wr(A_EO, eo_m);
    chk("R2 he+eo", elig_o, 32'h8);
    wait_load("R5 first pick", 3);
    ho_m = 32'h20; wr(A_HO, ho_m);
    pulse_evt(32'h20);
    chk("R2 ho+ep", elig_o, 32'h28);
    chk("R4 ep set", ep_o, 32'h20);
    ho_m = 0; wr(A_HO, ho_m);
    chk("R2 ep alone", elig_o, 32'h8);
  endtask

  task automatic t_nopreempt;
    set_prio(7, 7);
    eo_m |= 32'h80; wr(A_EO, eo_m);
    wr(A_SET_HE, 32'h80);
    chk("R7 higher eligible", elig_o, 32'h88);
    no_load("R7 running", 5);
    chk("R7 busy held", 32'(busy_o), 1);
  endtask

  task automatic t_strict;
    yld(YK_STRICT, 3, 0);
    wait_load("R8 strict release", 7);
    chk("R10 he kept", 32'(he_o[3]), 1);
    chk("R10 still elig", 32'(elig_o[3]), 1);
  endtask

  task automatic t_ge;
    set_prio(3, 7);
    yld(YK_STRICT, 7, 0);
    no_load("R8 equal not strict", 4);
    chk("R8 busy", 32'(busy_o), 1);
    yld(YK_GE, 7, 0);
    wait_load("R9 ge release", 3);
    chk("R10 he7 kept", 32'(he_o[7]), 1);
  endtask

  task automatic t_done_h;
    yld(YK_DONE_H, 3, 0);
    chk("R11 he cleared", 32'(he_o[3]), 0);
    chk("R11 busy dropped", 32'(busy_o), 0);
    wait_load("R11 repick", 7);
  endtask

  task automatic t_done_a;
    set_prio(9, 5);
    ho_m = 32'h200; wr(A_HO, ho_m);
    pulse_evt(32'h200);
    no_load("R7 ch9 waits", 2);
    yld(YK_DONE_A, 7, 0);
    chk("R11 he7 cleared", 32'(he_o[7]), 0);
    wait_load("R11 pick ch9", 9);
  endtask

  task automatic t_set_wins;
    yld(YK_DONE_A, 9, 32'h200);
    chk("R4 set beats clear", 32'(ep_o[9]), 1);
    wait_load("R4 ch9 reloaded", 9);
    yld(YK_DONE_A, 9, 0);
    chk("R11 ep cleared", 32'(ep_o[9]), 0);
    no_load("R6 sleep", 4);
    chk("R6 sleep busy", 32'(busy_o), 0);
    chk("R6 sleep elig", elig_o, 0);
  endtask

  task automatic t_prio0;
    eo_m |= 32'h1000; wr(A_EO, eo_m);
    wr(A_SET_HE, 32'h1000);
    chk("R6 prio0 elig", elig_o, 32'h1000);
    no_load("R6 prio0", 4);
    chk("R6 prio0 busy", 32'(busy_o), 0);
  endtask

  task automatic t_tie;
    set_prio(4, 4);
    set_prio(20, 4);
    eo_m |= 32'h0010_0010; wr(A_EO, eo_m);
    no_load("R5 not yet", 2);
    wr(A_SET_HE, 32'h0010_0010);
    wait_load("R5 tie low index", 4);
  endtask

  task automatic t_resched;
    set_prio(20, 6);
    no_load("R7 prio raise", 2);
    wr(A_CTRL, 32'h1);
    chk("R12 resched busy", 32'(busy_o), 0);
    wait_load("R12 resched pick", 20);
  endtask

  task automatic t_clr_he;
    wr(A_CLR_HE, 32'h10);
    chk("R3 clr he", he_o, 32'h0010_1000);
    chk("R3 clr elig", 32'(elig_o[4]), 0);
    no_load("R3 clr", 2);
  endtask

  task automatic t_rst_cmd;
    pulse_evt(32'h4000);
    wr(A_CTRL, 32'h2);
    chk("R12 reset he", he_o, 0);
    chk("R12 reset ep", ep_o, 0);
    chk("R12 reset busy", 32'(busy_o), 0);
    chk("R12 reset elig", elig_o, 0);
    no_load("R12 reset", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_elig();
    t_nopreempt();
    t_strict();
    t_ge();
    t_done_h();
    t_done_a();
    t_set_wins();
    t_prio0();
    t_tie();
    t_resched();
    t_clr_he();
    t_rst_cmd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule